// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width-modulated outputs from one input clock, and a simple word-addressed read/write port configures it. Each channel has its own clock divider, a period count and a duty count. A channel holds its active level for the first `(divider + 1) × duty` input cycles of every `(divider + 1) × period` cycle window. All channels share one control word that holds enables, polarities and drive modes. The four divider fields are packed into one shared word, with channel 0 in the highest field.

Each pin can drive both levels (push-pull). It can also pull only low and release the line for high (open-drain). For that case a separate output-enable pin is provided per channel. Software is expected to change the timing counts only while a channel is disabled. A disabled channel idles at its inactive level. Enabling it starts a fresh period from count zero.

Top module: `pwm4_ctrl`

## Requirements
- R1: After reset every register reads 0 and every channel sits at its inactive level with polarity 0, so `pwm_out` = 4'hF and `pwm_oe` = 4'hF.
- R2: Byte offset 0x00 is the control word: enable of channel n at bit n, polarity at bit 8+n, drive mode at bit 15+n. The period of channel n is at 0x04+8n and its duty at 0x08+8n, each in bits 15:0. Reads return stored values with all other bits 0.
- R3: The divider word at offset 0x24 holds four 6-bit fields, and channel n uses bits `(3-n)*6 +: 6`. Unused bits 31:24 read 0.
- R4: While enabled, a channel's pattern repeats every `(div+1)*period` input cycles. It is active for the first `(div+1)*duty` cycles of each repetition.
- R5: A duty of 0 keeps a channel inactive all period. A duty at or above the period keeps it active all period.
- R6: A disabled channel drives its inactive level and keeps its counters at zero. In the first cycle after its enable bit is set, it starts a new period at count zero, so it is active if its duty is nonzero.
- R7: With polarity 1 the active level is high and the inactive level is low. With polarity 0 both are inverted.
- R8: Drive mode 0 gives `pwm_out` = level and `pwm_oe` = 1. Drive mode 1 gives `pwm_out` = 0 and `pwm_oe` = 1 only while the level is low.
- R9: A write to any offset other than 0x00, 0x04..0x20 (word aligned) or 0x24 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that all counters step on |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 4 | Per-channel pin value |
| pwm_oe | output | 4 | Per-channel pin drive enable |

## Verification
A divider or period counter that slips by one state shows up at the pins within one period. The edge then moves by a whole tick relative to the reference, and the per-cycle comparison flags it in the cycle where the edges diverge. A counter that is not cleared while disabled shows up in the first cycle after re-enable: the output starts in the wrong phase. A decode fault shows up either as a wrong read-back or as timing taken from the wrong channel's field, and the latter diverges on the first tick.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

  // Bit position where channel ch's divider field starts; channel 0 is highest.
  function automatic int div_lsb(input int nch, input int div_w, input int ch);
    return (nch - 1 - ch) * div_w;
  endfunction

  // Pin level from the duty state and the polarity bit.
  function automatic logic pin_level(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction

  // {out, oe} for a level under push-pull (od=0) or open-drain (od=1).
  function automatic logic [1:0] pin_drive(input logic level, input logic od);
    return od ? {1'b0, ~level} : {level, 1'b1};
  endfunction

endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  output logic [NCH-1:0]              en,
  output logic [NCH-1:0]              pol,
  output logic [NCH-1:0]              od,
  output logic [NCH-1:0][CNT_W-1:0]   period,
  output logic [NCH-1:0][CNT_W-1:0]   duty,
  output logic [NCH-1:0][DIV_W-1:0]   div
);
  localparam int POL_BASE = 8;
  localparam int OD_BASE  = 15;
  localparam int PACK_W   = NCH * DIV_W;
  localparam logic [ADDR_W-1:0] DIV_OFF  = ADDR_W'(4 + 8 * NCH);
  localparam logic [ADDR_W-1:0] CH_FIRST = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] CH_LAST  = ADDR_W'(8 * NCH);

  logic [PACK_W-1:0] div_word;
  logic              hit_ctrl, hit_div, hit_chan, is_period;
  logic              hit_any;
  int                ch_idx;

  always_comb begin
    hit_ctrl  = (addr == '0);
    hit_div   = (addr == DIV_OFF);
    hit_chan  = (addr[1:0] == 2'b00) && (addr >= CH_FIRST) && (addr <= CH_LAST);
    is_period = addr[2];
    ch_idx    = int'((addr - CH_FIRST) >> 3);
    hit_any   = hit_ctrl || hit_div || hit_chan;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '0;
      pol      <= '0;
      od       <= '0;
      period   <= '0;
      duty     <= '0;
      div_word <= '0;
    end else if (wr) begin
      if (hit_ctrl) begin
        en  <= wdata[NCH-1:0];
        pol <= wdata[POL_BASE +: NCH];
        od  <= wdata[OD_BASE +: NCH];
      end
      if (hit_div) div_word <= wdata[PACK_W-1:0];
      if (hit_chan) begin
        if (is_period) period[ch_idx] <= wdata[CNT_W-1:0];
        else           duty[ch_idx]   <= wdata[CNT_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_div
    assign div[g] = div_word[div_lsb(NCH, DIV_W, g) +: DIV_W];
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl) begin
      rdata[NCH-1:0]         = en;
      rdata[POL_BASE +: NCH] = pol;
      rdata[OD_BASE +: NCH]  = od;
    end else if (hit_div) begin
      rdata[PACK_W-1:0] = div_word;
    end else if (hit_chan) begin
      rdata[CNT_W-1:0] = is_period ? period[ch_idx] : duty[ch_idx];
    end
  end

  // R9: a write outside the map leaves every register unchanged
  p_undef_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit_any) |=> ($stable(en) && $stable(pol) && $stable(od) &&
                          $stable(period) && $stable(duty) && $stable(div_word)));

endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
  import pwm4_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol,
  input  logic             od,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic [DIV_W-1:0] div,
  output logic             pad_out,
  output logic             pad_oe
);
  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] per_cnt;
  logic             tick;     // divider reached its limit this cycle
  logic             last;     // period counter at its final state
  logic             active;
  logic             level;

  assign tick   = en && (div_cnt == div);
  assign last   = (period <= CNT_W'(1)) || (per_cnt >= period - CNT_W'(1));
  assign active = en && (per_cnt < duty);
  assign level  = pin_level(active, pol);
  assign {pad_out, pad_oe} = pin_drive(level, od);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      per_cnt <= '0;
    end else if (!en) begin
      div_cnt <= '0;
      per_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      per_cnt <= last ? '0 : per_cnt + CNT_W'(1);
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  // R4: divider never passes its configured limit
  p_div_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $stable(div)) |-> (div_cnt <= div));

  // R4: period counter stays inside the period
  p_per_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && period >= CNT_W'(2) && $stable(period)) |-> (per_cnt < period));

  // R4: a tick on the last state wraps to zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last) |=> (per_cnt == '0));

  // R6: enabling starts from a clean count
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (per_cnt == '0 && div_cnt == '0));

  // R6: a disabled channel keeps zero counters
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (per_cnt == '0 && div_cnt == '0));

endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    pwm_oe
);
  logic [NCH-1:0]            en, pol, od;
  logic [NCH-1:0][CNT_W-1:0] period, duty;
  logic [NCH-1:0][DIV_W-1:0] div;

  pwm4_regs #(.NCH(NCH), .CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rdata(bus_rdata), .en(en), .pol(pol), .od(od),
    .period(period), .duty(duty), .div(div)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm4_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(en[g]), .pol(pol[g]), .od(od[g]),
      .period(period[g]), .duty(duty[g]), .div(div[g]),
      .pad_out(pwm_out[g]), .pad_oe(pwm_oe[g])
    );
  end

endmodule

// File: tb/pwm4_ctrl_tb.sv
module pwm4_ctrl_tb;
  localparam int CLK_NS = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out, pwm_oe;

  int vectors = 0;
  int errors  = 0;
  bit run_cmp = 0;

  // reference model state
  logic [3:0] m_en, m_pol, m_od;
  int         m_per[4], m_duty[4], t[4];
  logic [31:0] m_div;

  pwm4_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  always #(CLK_NS/2) clk = ~clk;

  // expected {out, oe} for channel c, from the requirement text
  function automatic logic [1:0] expect_pins(int c);
    int  d, ph;
    logic act, lvl;
    d   = (m_div >> ((3 - c) * 6)) & 63;
    ph  = (m_per[c] < 2) ? 0 : (t[c] / (d + 1)) % m_per[c];
    act = m_en[c] && (ph < m_duty[c]);
    lvl = act ? m_pol[c] : !m_pol[c];
    if (m_od[c]) return {1'b0, !lvl};
    return {lvl, 1'b1};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_od = 0; m_div = 0;
      for (int c = 0; c < 4; c++) begin m_per[c] = 0; m_duty[c] = 0; t[c] = 0; end
    end else begin
      for (int c = 0; c < 4; c++) begin
        logic nxt;
        nxt = (bus_wr && bus_addr == 0) ? bus_wdata[c] : m_en[c];
        if (m_en[c] && nxt) t[c] = t[c] + 1; else t[c] = 0;
      end
      if (bus_wr) begin
        if (bus_addr == 0) begin
          m_en = bus_wdata[3:0]; m_pol = bus_wdata[11:8]; m_od = bus_wdata[18:15];
        end else if (bus_addr == 6'h24) m_div = bus_wdata & 32'h00FF_FFFF;
        else for (int c = 0; c < 4; c++) begin
          if (bus_addr == 6'(4 + 8*c)) m_per[c]  = int'(bus_wdata[15:0]);
          if (bus_addr == 6'(8 + 8*c)) m_duty[c] = int'(bus_wdata[15:0]);
        end
      end
    end
  end

  // per-cycle comparison against the model (R4 R5 R7 R8)
  always @(negedge clk) begin
    if (run_cmp) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] e;
        e = expect_pins(c);
        vectors++;
        if ({pwm_out[c], pwm_oe[c]} !== e) begin
          errors++;
          $display("FAIL R4/R5/R7/R8 ch%0d t=%0d: got out/oe=%b%b expected %b%b",
                   c, t[c], pwm_out[c], pwm_oe[c], e[1], e[0]);
        end
      end
    end
  end

  task automatic write_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic check_read(input logic [5:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    vectors++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h: got %08h expected %08h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic check_pins(input int c, input logic eo, input logic ee, input string req);
    vectors++;
    if (pwm_out[c] !== eo || pwm_oe[c] !== ee) begin
      errors++;
      $display("FAIL %s ch%0d: got out/oe=%b%b expected %b%b", req, c, pwm_out[c], pwm_oe[c], eo, ee);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a <= 36; a += 4) check_read(6'(a), 32'h0, "R1");
    vectors++;
    if (pwm_out !== 4'hF || pwm_oe !== 4'hF) begin
      errors++;
      $display("FAIL R1 pins: got %h/%h expected F/F", pwm_out, pwm_oe);
    end
    run_cmp = 1;

    // R2: map and masking
    write_reg(6'h00, 32'hFFFF_FFF0);
    check_read(6'h00, 32'h0007_8F00, "R2");
    write_reg(6'h00, 32'h0);
    for (int c = 0; c < 4; c++) write_reg(6'(4 + 8*c), 32'hABCD_0000 | (32'h111 * (c + 1)));
    for (int c = 0; c < 4; c++) write_reg(6'(8 + 8*c), 32'h5A5A_0000 | (32'h22 * (c + 1)));
    for (int c = 0; c < 4; c++) check_read(6'(4 + 8*c), 32'h111 * (c + 1), "R2");
    for (int c = 0; c < 4; c++) check_read(6'(8 + 8*c), 32'h22 * (c + 1), "R2");
    // R3: divider word width
    write_reg(6'h24, 32'hFFFF_FFFF);
    check_read(6'h24, 32'h00FF_FFFF, "R3");

    // R9: undefined offsets
    write_reg(6'h28, 32'hFFFF_FFFF);
    write_reg(6'h3C, 32'hFFFF_FFFF);
    write_reg(6'h06, 32'hFFFF_FFFF);
    write_reg(6'h01, 32'hFFFF_FFFF);
    check_read(6'h00, 32'h0, "R9");
    check_read(6'h04, 32'h111, "R9");
    check_read(6'h08, 32'h22, "R9");
    check_read(6'h24, 32'h00FF_FFFF, "R9");
    check_pins(0, 1'b1, 1'b1, "R9");

    // configure: ch0 div1 per5 duty2; ch1 div0 per2 duty1; ch2 div2 per4 duty0; ch3 div0 per3 duty7
    write_reg(6'h24, (32'd1 << 18) | (32'd0 << 12) | (32'd2 << 6) | 32'd0);
    write_reg(6'h04, 5);  write_reg(6'h08, 2);
    write_reg(6'h0C, 2);  write_reg(6'h10, 1);
    write_reg(6'h14, 4);  write_reg(6'h18, 0);
    write_reg(6'h1C, 3);  write_reg(6'h20, 7);
    // pol: ch0=1 ch1=0 ch2=1 ch3=1; od: ch1 and ch2
    write_reg(6'h00, 32'h0000_0D0F | (32'b0110 << 15));
    // R6: first cycle after enable is count zero -> active
    check_pins(0, 1'b1, 1'b1, "R6");
    // R5: duty 0 open-drain pol1 -> low driven; duty above period active high
    check_pins(2, 1'b0, 1'b1, "R5");
    check_pins(3, 1'b1, 1'b1, "R5");
    // R8: ch1 pol0, active -> level low -> oe 1, out 0
    check_pins(1, 1'b0, 1'b1, "R8");
    // R3: ch0 active for (1+1)*2 = 4 cycles
    repeat (3) @(negedge clk);
    check_pins(0, 1'b1, 1'b1, "R3");
    @(negedge clk);
    check_pins(0, 1'b0, 1'b1, "R3");
    repeat (200) @(negedge clk);

    // R6: disable ch0, idle inactive, re-enable restarts
    write_reg(6'h00, 32'h0000_0D0E | (32'b0110 << 15));
    check_pins(0, 1'b0, 1'b1, "R6");
    repeat (40) @(negedge clk);
    check_pins(0, 1'b0, 1'b1, "R6");
    // R7: flip ch3 polarity while running
    write_reg(6'h00, 32'h0000_050F | (32'b0110 << 15));
    check_pins(0, 1'b1, 1'b1, "R6");
    check_pins(3, 1'b0, 1'b1, "R7");
    repeat (150) @(negedge clk);

    // R4: new periods on ch1 after disable
    write_reg(6'h00, 32'h0);
    write_reg(6'h0C, 7); write_reg(6'h10, 3);
    write_reg(6'h24, (32'd3 << 12));
    write_reg(6'h00, 32'h0000_0F0F);
    repeat (300) @(negedge clk);

    run_cmp = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule